// File: doc/BRIEF.md
# General-Purpose Pin Port Bank with Per-Pin Interrupt Triggers

This block holds five general-purpose pin ports behind a small word-addressed register bus. Port 0 is narrow (8 pins) and its pins can raise interrupts. Ports 1 to 4 are wide (18 pins each) and carry plain data only. Each port has a data-out register and an output-enable register, both writable. It also has a read-only data-in register that returns the pin levels after a two-flop synchronizer. The pad cells are outside the block: it drives the output value and enable of each pin and takes the pin level back in.

Each narrow-port pin has a 3-bit trigger field. The field selects one of three level triggers (high, low, constant one) or one of three edge triggers (rising, falling, any). Edge events are caught in a sticky bit that stays set until software writes a one to the matching bit of the acknowledge register. The per-pin status is ANDed with a mask register and can be read as a masked status word. The single interrupt output is the OR of that word.

Register map (word addresses, `p` = port index 0..4): data-out at `4p`, output enable at `4p+1` and data in at `4p+2`. Address `4p+3` reads zero. The trigger fields are at 20, the mask at 21, the masked status at 22 and the acknowledge at 23.

Top module: `pio_bank`

## Requirements
- R1: After reset all data-out, output-enable, mask and trigger registers read zero, no sticky event is held, every output-enable pin is low and `irq` is low.
- R2: A bus write sets the data-out or output-enable register of the addressed port only. A read returns the stored value with the bits above the port width (8 for port 0, 18 for ports 1 to 4) reading zero.
- R3: Each pin's output value equals its data-out bit, and each pin's enable equals its output-enable bit (1 drives the pin, 0 leaves it as an input).
- R4: A data-in register returns the pin levels through two flops. A level applied before clock edge k is not visible after edge k and is visible after edge k+1.
- R5: The trigger register holds one 3-bit field per narrow-port pin, with pin i at bits [3i+2:3i]. The codes are 0 off, 1 high level, 2 low level, 3 constant one, 4 rising, 5 falling and 6 any edge. Code 7 behaves as off.
- R6: The level triggers are not latched. Their status follows the synchronized pin and is visible from the same cycle as the data-in register.
- R7: An edge trigger sets a sticky bit one cycle after the synchronized level changes, so a change applied before edge k shows in the status after edge k+2. The bit stays set until acknowledged.
- R8: Writing the acknowledge register with bit i at 1 clears sticky bit i, and a 0 bit leaves it unchanged. If a new edge arrives in the same cycle as the acknowledge, the bit stays set.
- R9: The masked status register reads as the per-pin status ANDed with the mask register, and `irq` is high exactly when that word is non-zero.
- R10: Writes to the data-in and masked status addresses change no register and no pin. The acknowledge address and the unused offset `4p+3` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| pin_a_in | input | 8 | Narrow port pin levels |
| pin_a_out | output | 8 | Narrow port output values |
| pin_a_oe | output | 8 | Narrow port output enables |
| pin_w_in | input | 72 | Wide port pin levels, port 1 in the low 18 bits |
| pin_w_out | output | 72 | Wide port output values |
| pin_w_oe | output | 72 | Wide port output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the clock edge that captures the strobe, and reads are combinational, so the bench reads back half a cycle after a write. A pin change that goes in at edge k shows in the data-in register and in the level-trigger status after edge k+1, and in the edge-trigger status after edge k+2. The bench samples in the cycle before each of these edges, where the old value is still due, and again just after, where the new value is due. The trigger sweep runs every code across many pin transition patterns. It also places an acknowledge in the same edge as a new event to check that the new event wins.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int TRIG_W = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RISE = 3'd4,
    TRIG_FALL = 3'd5,
    TRIG_ANY  = 3'd6,
    TRIG_RSVD = 3'd7
  } trig_e;

  // True when the trigger code latches events
  function automatic logic trig_is_edge(input logic [TRIG_W-1:0] code);
    trig_e t;
    t = trig_e'(code);
    return (t == TRIG_RISE) || (t == TRIG_FALL) || (t == TRIG_ANY);
  endfunction

  // Event detected this cycle for one pin
  function automatic logic trig_edge_hit(input logic [TRIG_W-1:0] code,
                                         input logic cur, input logic prev);
    logic hit;
    case (trig_e'(code))
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      TRIG_ANY:  hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Status bit seen by software for one pin
  function automatic logic trig_status(input logic [TRIG_W-1:0] code,
                                       input logic cur, input logic held);
    logic st;
    case (trig_e'(code))
      TRIG_HIGH: st = cur;
      TRIG_LOW:  st = ~cur;
      TRIG_SET:  st = 1'b1;
      TRIG_RISE, TRIG_FALL, TRIG_ANY: st = held;
      default:   st = 1'b0;
    endcase
    return st;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

  // cycles since reset, saturating, so $past never reaches before reset
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (q == $past(d, 2)));

endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dout,
  input  logic         wr_oe,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      oe   <= '0;
    end else begin
      if (wr_dout) dout <= wdata;
      if (wr_oe)   oe   <= wdata;
    end
  end

  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_oe |=> $stable(oe));
  assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dout |=> $stable(dout));

endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit
  import pio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        pin_s,
  input  logic [N*TRIG_W-1:0] modes,
  input  logic [N-1:0]        mask,
  input  logic                ack_we,
  input  logic [N-1:0]        ack_bits,
  output logic [N-1:0]        masked,
  output logic                irq
);

  logic [N-1:0] prev_q;
  logic [N-1:0] sticky_q;
  logic [N-1:0] edge_evt;   // event seen this cycle
  logic [N-1:0] ack_hit;    // acknowledge per pin
  logic [N-1:0] status;

  assign ack_hit = ack_we ? ack_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign edge_evt[i] = trig_edge_hit(modes[i*TRIG_W +: TRIG_W], pin_s[i], prev_q[i]);
    assign status[i]   = trig_status(modes[i*TRIG_W +: TRIG_W], pin_s[i], sticky_q[i]);

    assert_edge_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] |=> sticky_q[i]);
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[i] && !ack_hit[i]) |=> sticky_q[i]);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[i] && !edge_evt[i]) |=> !sticky_q[i]);
    assert_edge_only_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] |-> trig_is_edge(modes[i*TRIG_W +: TRIG_W]));
  end

  // new events win over a same-cycle acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~ack_hit) | edge_evt;
  end

  assign masked = status & mask;
  assign irq    = |masked;

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int A_W      = 8,
  parameter int W_W      = 18,
  parameter int NUM_WIDE = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [A_W-1:0]          pin_a_in,
  output logic [A_W-1:0]          pin_a_out,
  output logic [A_W-1:0]          pin_a_oe,
  input  logic [NUM_WIDE*W_W-1:0] pin_w_in,
  output logic [NUM_WIDE*W_W-1:0] pin_w_out,
  output logic [NUM_WIDE*W_W-1:0] pin_w_oe,
  output logic                    irq
);

  localparam int NUM_PORTS = NUM_WIDE + 1;
  localparam int MODE_W    = A_W * TRIG_W;
  localparam int SEL_W     = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] ADR_MODE = ADDR_W'(NUM_PORTS * 4);
  localparam logic [ADDR_W-1:0] ADR_MASK = ADDR_W'(NUM_PORTS * 4 + 1);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(NUM_PORTS * 4 + 2);
  localparam logic [ADDR_W-1:0] ADR_ACK  = ADDR_W'(NUM_PORTS * 4 + 3);

  logic [NUM_PORTS-1:0] wr_dout, wr_oe;
  logic [DATA_W-1:0]    dout_x [NUM_PORTS];
  logic [DATA_W-1:0]    oe_x   [NUM_PORTS];
  logic [DATA_W-1:0]    din_x  [NUM_PORTS];

  logic [A_W-1:0]          sync_a;
  logic [NUM_WIDE*W_W-1:0] sync_w;
  logic [MODE_W-1:0]       mode_q;
  logic [A_W-1:0]          mask_q;
  logic [A_W-1:0]          masked;
  logic                    ack_we;
  logic [SEL_W-1:0]        sel_port;
  logic [1:0]              sel_ofs;

  assign sel_port = bus_addr[ADDR_W-1:2];
  assign sel_ofs  = bus_addr[1:0];
  assign ack_we   = bus_we && (bus_addr == ADR_ACK);

  pio_sync #(.W(A_W)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .d(pin_a_in), .q(sync_a)
  );
  pio_sync #(.W(NUM_WIDE*W_W)) u_sync_w (
    .clk(clk), .rst_n(rst_n), .d(pin_w_in), .q(sync_w)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign wr_dout[p] = bus_we && (bus_addr == ADDR_W'(p * 4));
    assign wr_oe[p]   = bus_we && (bus_addr == ADDR_W'(p * 4 + 1));
    if (p == 0) begin : g_narrow
      pio_port_regs #(.W(A_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_dout(wr_dout[p]), .wr_oe(wr_oe[p]),
        .wdata(bus_wdata[A_W-1:0]),
        .dout(pin_a_out), .oe(pin_a_oe)
      );
      assign dout_x[p] = DATA_W'(pin_a_out);
      assign oe_x[p]   = DATA_W'(pin_a_oe);
      assign din_x[p]  = DATA_W'(sync_a);
    end else begin : g_wide
      pio_port_regs #(.W(W_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_dout(wr_dout[p]), .wr_oe(wr_oe[p]),
        .wdata(bus_wdata[W_W-1:0]),
        .dout(pin_w_out[(p-1)*W_W +: W_W]), .oe(pin_w_oe[(p-1)*W_W +: W_W])
      );
      assign dout_x[p] = DATA_W'(pin_w_out[(p-1)*W_W +: W_W]);
      assign oe_x[p]   = DATA_W'(pin_w_oe[(p-1)*W_W +: W_W]);
      assign din_x[p]  = DATA_W'(sync_w[(p-1)*W_W +: W_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADR_MODE) mode_q <= bus_wdata[MODE_W-1:0];
      if (bus_addr == ADR_MASK) mask_q <= bus_wdata[A_W-1:0];
    end
  end

  pio_irq_unit #(.N(A_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .pin_s(sync_a), .modes(mode_q), .mask(mask_q),
    .ack_we(ack_we), .ack_bits(bus_wdata[A_W-1:0]),
    .masked(masked), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_MODE)      bus_rdata = DATA_W'(mode_q);
    else if (bus_addr == ADR_MASK) bus_rdata = DATA_W'(mask_q);
    else if (bus_addr == ADR_STAT) bus_rdata = DATA_W'(masked);
    else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel_port == SEL_W'(p)) begin
          case (sel_ofs)
            2'd0:    bus_rdata = dout_x[p];
            2'd1:    bus_rdata = oe_x[p];
            2'd2:    bus_rdata = din_x[p];
            default: bus_rdata = '0;
          endcase
        end
      end
    end
  end

  // a pin set to the constant-one code and unmasked must hold the line high
  for (genvar i = 0; i < A_W; i++) begin : g_chk
    assert_set_code_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i*TRIG_W +: TRIG_W] == TRIG_SET && mask_q[i]) |-> irq);
    assert_off_code_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q[i*TRIG_W +: TRIG_W] == TRIG_OFF || mode_q[i*TRIG_W +: TRIG_W] == TRIG_RSVD)
       && mask_q == A_W'(1 << i)) |-> !irq);
  end

  assert_ack_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_ACK) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_pio_bank.sv
`timescale 1ns/1ps
module tb_pio_bank;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int WW = 18;
  localparam int NW = 4;
  localparam logic [AW-1:0] A_MODE = 5'd20;
  localparam logic [AW-1:0] A_MASK = 5'd21;
  localparam logic [AW-1:0] A_STAT = 5'd22;
  localparam logic [AW-1:0] A_ACK  = 5'd23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [7:0] pin_a_in = '0;
  logic [7:0] pin_a_out, pin_a_oe;
  logic [NW*WW-1:0] pin_w_in = '0;
  logic [NW*WW-1:0] pin_w_out, pin_w_oe;
  logic irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pio_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_w_in(pin_w_in), .pin_w_out(pin_w_out), .pin_w_oe(pin_w_oe),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // expected status bit for one pin, from the code table of R5
  function automatic logic model_bit(input int code, input logic a, input logic b, input bit early);
    if (code == 1) return b;
    if (code == 2) return !b;
    if (code == 3) return 1'b1;
    if (early) return 1'b0;
    if (code == 4) return (!a && b);
    if (code == 5) return (a && !b);
    if (code == 6) return (a != b);
    return 1'b0;
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] pat;
    logic [DW-1:0] exp_w;
    logic [7:0] a, b, msk, exp_s, exp_e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int p = 0; p < 5; p++) begin
      rd(AW'(p*4), v);   chk("R1 dout", v, 0);
      rd(AW'(p*4+1), v); chk("R1 oe", v, 0);
    end
    rd(A_MODE, v); chk("R1 mode", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", DW'(irq), 0);
    chk("R1 pin oe", DW'(pin_a_oe), 0);
    chk("R1 wide pin oe", DW'(pin_w_oe == '0), 1);

    // R2, R3: register write/readback and pin drive on every port
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 5; p++) begin
        pat = 32'hA5C3_9E17 ^ DW'(k * 32'h1357_9BDF) ^ DW'(p * 32'h0F0F_3C3C);
        exp_w = (p == 0) ? (pat & 32'hFF) : (pat & 32'h3FFFF);
        wr(AW'(p*4), pat);
        wr(AW'(p*4+1), ~pat);
        rd(AW'(p*4), v);   chk("R2 dout readback", v, exp_w);
        rd(AW'(p*4+1), v); chk("R2 oe readback", v, (p == 0) ? (~pat & 32'hFF) : (~pat & 32'h3FFFF));
        if (p == 0) begin
          chk("R3 pin out", DW'(pin_a_out), exp_w);
          chk("R3 pin oe", DW'(pin_a_oe), ~pat & 32'hFF);
        end else begin
          chk("R3 wide pin out", DW'(pin_w_out[(p-1)*WW +: WW]), exp_w);
          chk("R3 wide pin oe", DW'(pin_w_oe[(p-1)*WW +: WW]), ~pat & 32'h3FFFF);
        end
      end
    end
    // R2: writing port 2 leaves port 1 alone
    rd(AW'(4), exp_w);
    wr(AW'(8), 32'h0);
    rd(AW'(4), v); chk("R2 other port unchanged", v, exp_w);

    // R4: wide data-in timing
    for (int p = 1; p < 5; p++) begin
      pat = DW'(p * 32'h2AAB5) & 32'h3FFFF;
      @(negedge clk);
      rd(AW'(p*4+2), exp_w);
      pin_w_in[(p-1)*WW +: WW] = pat[WW-1:0];
      @(negedge clk);
      rd(AW'(p*4+2), v); chk("R4 din one edge", v, exp_w);
      @(negedge clk);
      rd(AW'(p*4+2), v); chk("R4 din two edges", v, pat);
    end

    // R10: read-only and unused addresses
    rd(AW'(6), exp_w);
    rd(AW'(4), pat);
    wr(AW'(6), 32'hFFFF_FFFF);
    rd(AW'(6), v); chk("R10 din write ignored", v, exp_w);
    rd(AW'(4), v); chk("R10 dout untouched by din write", v, pat);
    wr(A_STAT, 32'hFF);
    rd(A_STAT, v); chk("R10 status write ignored", v, 0);
    rd(A_MODE, v); chk("R10 mode untouched", v, 0);
    rd(A_ACK, v);  chk("R10 ack reads zero", v, 0);
    rd(AW'(7), v); chk("R10 unused offset", v, 0);

    // R5, R6, R7, R9: trigger sweep, all pins share one code
    for (int m = 0; m < 8; m++) begin
      for (int ka = 0; ka < 16; ka++) begin
        for (int kb = 0; kb < 16; kb++) begin
          a = 8'((ka * 37 + 5) & 8'hFF);
          b = 8'((kb * 89 + 3) & 8'hFF);
          msk = 8'(~(ka * 13 + kb * 7));
          wr(A_MODE, {8{3'(m)}});
          wr(A_MASK, DW'(msk));
          pin_a_in = a;
          repeat (3) @(negedge clk);
          wr(A_ACK, 32'hFF);
          pin_a_in = b;
          @(negedge clk);
          @(negedge clk);
          exp_e = '0; exp_s = '0;
          for (int i = 0; i < 8; i++) begin
            exp_e[i] = model_bit(m, a[i], b[i], 1'b1);
            exp_s[i] = model_bit(m, a[i], b[i], 1'b0);
          end
          rd(AW'(2), v);  chk("R4 narrow din", v, DW'(b));
          rd(A_STAT, v);  chk("R6 status before edge latch", v, DW'(exp_e & msk));
          @(negedge clk);
          rd(A_STAT, v);  chk("R7 status after edge latch", v, DW'(exp_s & msk));
          chk("R9 irq", DW'(irq), DW'((exp_s & msk) != 0));
        end
      end
    end

    // R8: acknowledge behaviour on rising edge code
    wr(A_MODE, {8{3'd4}});
    wr(A_MASK, 32'hFF);
    pin_a_in = 8'h00;
    repeat (3) @(negedge clk);
    wr(A_ACK, 32'hFF);
    pin_a_in = 8'h0F;
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R8 events set", v, 32'h0F);
    wr(A_ACK, 32'h00);
    rd(A_STAT, v); chk("R8 zero ack keeps", v, 32'h0F);
    wr(A_ACK, 32'h05);
    rd(A_STAT, v); chk("R8 partial ack", v, 32'h0A);
    wr(A_ACK, 32'h0A);
    rd(A_STAT, v); chk("R8 full ack", v, 32'h00);
    chk("R8 irq low after ack", DW'(irq), 0);
    // new event in the same edge as its acknowledge
    pin_a_in = 8'h1F;
    @(negedge clk);
    wr(A_ACK, 32'h10);
    rd(A_STAT, v); chk("R8 set beats ack", v, 32'h10);
    wr(A_ACK, 32'h10);
    rd(A_STAT, v); chk("R8 cleared later", v, 32'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule